// File: doc/BRIEF.md
# Operand Addressing and Register Unit

This block holds the sixteen 16-bit registers of a small accumulator-style processor and resolves its 8-bit operand specifiers. A source operand can come from a device, a signed short immediate, a register (with or without a post-increment) or memory (addressed by a register, with or without a post-increment). A destination can be a device, a register, or a memory store addressed by a register, with an optional post-increment of that register. One fixed destination code stores through register 12 and then decrements it, which gives a push-style stack.

Two of the general registers also serve as program counters. Register 15 is the program counter in normal operation and register 14 is the program counter during interrupt service. A mode input picks which one drives the program counter output. A post-incremented memory read through the active program counter fetches the word that follows the instruction and steps past it. This is how full-width immediates are loaded.

The sequencer issues one operation per `op_start` while idle. Register and immediate operations complete in one cycle. Memory and device operations raise a request, hold it stable until the acknowledge arrives, and then complete. This lets fast and slow targets share the same ports.

Top module: `opnd_unit`

## Requirements
- R1: After reset all sixteen registers read as 0, `pc_out` is 0, and `mem_req`, `dev_req`, `op_done` and `op_busy` are low.
- R2: A source specifier `10iiiiii` returns `iiiiii` sign-extended to 16 bits (range -32..31), with `op_done` high in the cycle after the start edge.
- R3: Source `1100rrrr` returns register rrrr unchanged. Source `1101rrrr` returns its old value and then increments it modulo 2^16. Both complete one cycle after start.
- R4: Destination `1100rrrr` writes `op_wdata` into register rrrr.
- R5: Source `1110rrrr` and `1111rrrr` read memory at the register's value from before any update. `op_rdata` is `mem_rdata` as seen at the acknowledge. `1111rrrr` increments the register in the acknowledge cycle.
- R6: Destination `1110rrrr` and `1111rrrr` store `op_wdata` with `mem_we` high at the register's address. `1111rrrr` then increments the register.
- R7: Destination code `11111010` stores at the address in register 12 and then decrements register 12 modulo 2^16. This replaces the post-increment of register 10.
- R8: A memory or device request stays high with stable address, select, direction and write data until its acknowledge. It drops in the cycle after the acknowledge, and `op_done` pulses in that same cycle.
- R9: Specifier `0sssssss` accesses device sss (`dev_sel` = low 7 bits) with `dev_we` equal to the direction. A device read returns `dev_rdata` as seen at the acknowledge.
- R10: `pc_out` equals register 15 when `irq_mode` is 0 and register 14 when it is 1.
- R11: A source `1111rrrr` through the active program counter returns the word at the program counter address and advances `pc_out` by one.
- R12: An `op_start` while `op_busy` is high is ignored: no register changes.
- R13: Destination specifiers `10xxxxxx` and `1101xxxx` complete one cycle after start with no request and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_mode | input | 1 | Interrupt service active; selects register 14 as program counter |
| op_start | input | 1 | Start an operation (taken only when idle) |
| op_write | input | 1 | 1: specifier is a destination, 0: a source |
| op_spec | input | 8 | Operand specifier |
| op_wdata | input | 16 | Data for a destination |
| op_busy | output | 1 | Memory or device access in progress |
| op_done | output | 1 | One-cycle completion pulse |
| op_rdata | output | 16 | Source value, valid with `op_done` of a source operation |
| pc_out | output | 16 | Active program counter |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |
| dev_req | output | 1 | Device request |
| dev_we | output | 1 | Device write enable |
| dev_sel | output | 7 | Device number |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data |
| dev_ack | input | 1 | Device acknowledge |

## Verification
A wrong register value does not show at once. It appears at the next register read, at the next memory address formed from that register, or on `pc_out` straight away when the register is 14 or 15. The bench keeps a register model, compares every access address and returned value against it, and dumps the whole file after directed cases. A lost or doubled post-update therefore shows on the next use of that register. A request that moves or drops before its acknowledge is seen within the same wait, because acknowledges are delayed at random by up to three cycles.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
    localparam int DW   = 16;
    localparam int NREG = 16;
    localparam int RW   = $clog2(NREG);
    localparam int SPW  = 8;
    localparam int DEVW = 7;
    localparam int IMMW = 6;

    typedef enum logic [2:0] {K_NOP, K_DEV, K_IMM, K_REG, K_MEM} kind_e;
    typedef enum logic [1:0] {P_NONE, P_INC, P_DEC} post_e;
    typedef enum logic [1:0] {S_IDLE, S_MEM, S_DEV} st_e;

    typedef struct packed {
        kind_e            kind;
        logic [RW-1:0]    idx;
        post_e            post;
        logic [DW-1:0]    imm;
        logic [DEVW-1:0]  dsel;
    } dec_t;

    typedef struct packed {
        st_e                        st;
        logic [NREG-1:0][DW-1:0]    regs;
        logic [DW-1:0]              rdata;
        logic                       done;
        logic                       mreq;
        logic                       dreq;
        logic                       we;
        logic [DW-1:0]              addr;
        logic [DW-1:0]              wdat;
        logic [DEVW-1:0]            dsel;
        logic [RW-1:0]              pidx;
        post_e                      post;
    } st_t;
endpackage

// File: rtl/opnd_decode.sv
module opnd_decode
    import opnd_pkg::*;
#(
    parameter int SP_IDX = 12
) (
    input  logic           is_dst,
    input  logic [SPW-1:0] spec,
    output dec_t           dec
);
    localparam logic [SPW-1:0] PUSH_CODE = 8'hFA;

    always_comb begin
        dec.kind = K_NOP;
        dec.idx  = spec[RW-1:0];
        dec.post = P_NONE;
        dec.imm  = DW'($signed(spec[IMMW-1:0]));
        dec.dsel = spec[DEVW-1:0];
        if (!spec[7]) begin
            dec.kind = K_DEV;
        end else if (!spec[6]) begin
            dec.kind = is_dst ? K_NOP : K_IMM;
        end else begin
            case (spec[5:4])
                2'b00: dec.kind = K_REG;
                2'b01: begin
                    dec.kind = is_dst ? K_NOP : K_REG;
                    dec.post = P_INC;
                end
                2'b10: dec.kind = K_MEM;
                default: begin
                    dec.kind = K_MEM;
                    dec.post = P_INC;
                    if (is_dst && spec == PUSH_CODE) begin
                        dec.idx  = RW'(SP_IDX);
                        dec.post = P_DEC;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/opnd_pc_sel.sv
module opnd_pc_sel
    import opnd_pkg::*;
(
    input  logic          irq_mode,
    input  logic [DW-1:0] pc_norm,
    input  logic [DW-1:0] pc_irq,
    output logic [DW-1:0] pc
);
    always_comb pc = irq_mode ? pc_irq : pc_norm;
endmodule

// File: rtl/opnd_unit.sv
module opnd_unit
    import opnd_pkg::*;
#(
    parameter int PC_NORM = 15,
    parameter int PC_IRQ  = 14,
    parameter int SP_IDX  = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_mode,
    input  logic            op_start,
    input  logic            op_write,
    input  logic [SPW-1:0]  op_spec,
    input  logic [DW-1:0]   op_wdata,
    output logic            op_busy,
    output logic            op_done,
    output logic [DW-1:0]   op_rdata,
    output logic [DW-1:0]   pc_out,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack,
    output logic            dev_req,
    output logic            dev_we,
    output logic [DEVW-1:0] dev_sel,
    output logic [DW-1:0]   dev_wdata,
    input  logic [DW-1:0]   dev_rdata,
    input  logic            dev_ack
);
    st_t  s_d, s_q;
    dec_t dec;

    opnd_decode #(.SP_IDX(SP_IDX)) u_dec (
        .is_dst (op_write),
        .spec   (op_spec),
        .dec    (dec)
    );

    opnd_pc_sel u_pc (
        .irq_mode (irq_mode),
        .pc_norm  (s_q.regs[PC_NORM]),
        .pc_irq   (s_q.regs[PC_IRQ]),
        .pc       (pc_out)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            S_IDLE: begin
                if (op_start) begin
                    case (dec.kind)
                        K_IMM: begin
                            s_d.rdata = dec.imm;
                            s_d.done  = 1'b1;
                        end
                        K_REG: begin
                            if (op_write) begin
                                s_d.regs[dec.idx] = op_wdata;
                            end else begin
                                s_d.rdata = s_q.regs[dec.idx];
                                if (dec.post == P_INC)
                                    s_d.regs[dec.idx] = s_q.regs[dec.idx] + 1'b1;
                            end
                            s_d.done = 1'b1;
                        end
                        K_MEM: begin
                            s_d.st   = S_MEM;
                            s_d.mreq = 1'b1;
                            s_d.we   = op_write;
                            s_d.addr = s_q.regs[dec.idx];
                            s_d.wdat = op_wdata;
                            s_d.pidx = dec.idx;
                            s_d.post = dec.post;
                        end
                        K_DEV: begin
                            s_d.st   = S_DEV;
                            s_d.dreq = 1'b1;
                            s_d.we   = op_write;
                            s_d.dsel = dec.dsel;
                            s_d.wdat = op_wdata;
                        end
                        default: s_d.done = 1'b1;
                    endcase
                end
            end
            S_MEM: begin
                if (mem_ack) begin
                    s_d.st   = S_IDLE;
                    s_d.mreq = 1'b0;
                    s_d.done = 1'b1;
                    if (!s_q.we) s_d.rdata = mem_rdata;
                    case (s_q.post)
                        P_INC:   s_d.regs[s_q.pidx] = s_q.regs[s_q.pidx] + 1'b1;
                        P_DEC:   s_d.regs[s_q.pidx] = s_q.regs[s_q.pidx] - 1'b1;
                        default: ;
                    endcase
                end
            end
            S_DEV: begin
                if (dev_ack) begin
                    s_d.st   = S_IDLE;
                    s_d.dreq = 1'b0;
                    s_d.done = 1'b1;
                    if (!s_q.we) s_d.rdata = dev_rdata;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= S_IDLE;
            s_q.post <= P_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign op_busy   = (s_q.st != S_IDLE);
    assign op_done   = s_q.done;
    assign op_rdata  = s_q.rdata;
    assign mem_req   = s_q.mreq;
    assign mem_we    = s_q.we;
    assign mem_addr  = s_q.addr;
    assign mem_wdata = s_q.wdat;
    assign dev_req   = s_q.dreq;
    assign dev_we    = s_q.we;
    assign dev_sel   = s_q.dsel;
    assign dev_wdata = s_q.wdat;
endmodule

// File: rtl/opnd_unit_chk.sv
module opnd_unit_chk
    import opnd_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            op_start,
    input logic            op_write,
    input logic [SPW-1:0]  op_spec,
    input logic            op_busy,
    input logic            op_done,
    input logic [DW-1:0]   op_rdata,
    input logic            mem_req,
    input logic            mem_we,
    input logic [DW-1:0]   mem_addr,
    input logic [DW-1:0]   mem_wdata,
    input logic [DW-1:0]   mem_rdata,
    input logic            mem_ack,
    input logic            dev_req,
    input logic            dev_we,
    input logic [DEVW-1:0] dev_sel,
    input logic [DW-1:0]   dev_wdata,
    input logic            dev_ack
);
    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R8
    mem_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req && op_done);

    // R9
    dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req && !dev_ack |=> dev_req && $stable(dev_sel) && $stable(dev_we) && $stable(dev_wdata));

    // R9
    dev_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req && dev_ack |=> !dev_req && op_done);

    // R5
    mem_load_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !mem_we |=> op_rdata == $past(mem_rdata));

    // R2
    short_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && !op_busy && !op_write && op_spec[7:6] == 2'b10
        |=> op_done && op_rdata == DW'($signed($past(op_spec[IMMW-1:0]))));

    // R13
    dst_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && !op_busy && op_write && (op_spec[7:6] == 2'b10 || op_spec[7:4] == 4'hD)
        |=> op_done && !mem_req && !dev_req);

    // R8
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && dev_req));
endmodule

bind opnd_unit opnd_unit_chk u_chk (.*);

// File: tb/opnd_unit_tb.sv
`timescale 1ns/1ps
module opnd_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_mode = 1'b0;
    logic        op_start = 1'b0;
    logic        op_write = 1'b0;
    logic [7:0]  op_spec = '0;
    logic [15:0] op_wdata = '0;
    logic        op_busy, op_done;
    logic [15:0] op_rdata, pc_out;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        dev_req, dev_we;
    logic [6:0]  dev_sel;
    logic [15:0] dev_wdata;
    logic [15:0] dev_rdata = '0;
    logic        dev_ack = 1'b0;

    always #4 clk = ~clk;

    opnd_unit u_dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] mreg [16];
    string ctx = "";

    logic        saw_m, saw_d, c_we;
    logic [15:0] c_addr, c_wd, got;
    logic [6:0]  c_sel;
    int          lat;
    bit          stable_ok;

    function automatic logic [15:0] mem_val(logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    function automatic logic [15:0] dev_val(logic [6:0] s);
        return {s, 9'h15B};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, ctx, act, exp);
        end
    endtask

    task automatic run(input logic w, input logic [7:0] sp, input logic [15:0] wd, input bit poke);
        int  dly;
        bit  poked;
        poked = 0;
        saw_m = 0; saw_d = 0; stable_ok = 1;
        @(negedge clk);
        op_start = 1'b1; op_write = w; op_spec = sp; op_wdata = wd;
        @(negedge clk);
        op_start = 1'b0;
        lat = 1;
        dly = poke ? 3 : $urandom_range(0, 3);
        while (!op_done && lat < 50) begin
            mem_ack = 1'b0; dev_ack = 1'b0;
            if (mem_req) begin
                if (!saw_m) begin
                    c_addr = mem_addr; c_we = mem_we; c_wd = mem_wdata;
                end else if (mem_addr !== c_addr || mem_we !== c_we || mem_wdata !== c_wd) begin
                    stable_ok = 0;
                end
                saw_m = 1;
                if (dly == 0) begin mem_ack = 1'b1; mem_rdata = mem_val(mem_addr); end
                else dly--;
            end
            if (dev_req) begin
                if (!saw_d) begin
                    c_sel = dev_sel; c_we = dev_we; c_wd = dev_wdata;
                end else if (dev_sel !== c_sel || dev_we !== c_we || dev_wdata !== c_wd) begin
                    stable_ok = 0;
                end
                saw_d = 1;
                if (dly == 0) begin dev_ack = 1'b1; dev_rdata = dev_val(dev_sel); end
                else dly--;
            end
            if (poke && !poked && (mem_req || dev_req)) begin
                op_start = 1'b1; op_write = 1'b1; op_spec = 8'hC3; op_wdata = 16'hDEAD;
                poked = 1;
            end
            @(negedge clk);
            op_start = 1'b0;
            lat++;
        end
        mem_ack = 1'b0; dev_ack = 1'b0;
        got = op_rdata;
        chk("R8 completion", 16'(lat < 50), 16'd1);
        if (saw_m || saw_d) chk("R8 request stable until ack", 16'(stable_ok), 16'd1);
        chk("R8 request dropped", {14'd0, mem_req, dev_req}, 16'd0);
    endtask

    task automatic do_op(input logic w, input logic [7:0] sp, input logic [15:0] wd, input bit poke);
        logic [3:0]  r;
        logic [15:0] a;
        bit          push;
        r = sp[3:0];
        run(w, sp, wd, poke);
        if (!sp[7]) begin
            chk("R9 device request", 16'(saw_d), 16'd1);
            chk("R9 device select", {9'd0, c_sel}, {9'd0, sp[6:0]});
            chk("R9 device direction", 16'(c_we), 16'(w));
            if (w) chk("R9 device write data", c_wd, wd);
            else   chk("R9 device read data", got, dev_val(sp[6:0]));
        end else if (!sp[6]) begin
            if (!w) begin
                chk("R2 short immediate", got, 16'($signed(sp[5:0])));
                chk("R2 latency", 16'(lat), 16'd1);
            end else begin
                chk("R13 no request", {14'd0, saw_m, saw_d}, 16'd0);
                chk("R13 latency", 16'(lat), 16'd1);
            end
        end else if (!sp[5]) begin
            if (!sp[4]) begin
                if (w) mreg[r] = wd;
                else   chk("R3 register read", got, mreg[r]);
                chk("R3/R4 latency", 16'(lat), 16'd1);
            end else if (w) begin
                chk("R13 no request", {14'd0, saw_m, saw_d}, 16'd0);
            end else begin
                chk("R3 post-increment read", got, mreg[r]);
                mreg[r] = mreg[r] + 16'd1;
            end
        end else begin
            push = w && (sp == 8'hFA);
            a = push ? mreg[12] : mreg[r];
            chk("R5/R6 memory request", 16'(saw_m), 16'd1);
            chk(push ? "R7 push address" : "R5/R6 address", c_addr, a);
            chk("R6 direction", 16'(c_we), 16'(w));
            if (w) chk("R6 store data", c_wd, wd);
            else   chk("R5 load data", got, mem_val(a));
            if (push) mreg[12] = mreg[12] - 16'd1;
            else if (sp[4]) mreg[r] = mreg[r] + 16'd1;
        end
        chk("R10 active program counter", pc_out, irq_mode ? mreg[14] : mreg[15]);
    endtask

    task automatic dump(string why);
        ctx = why;
        for (int i = 0; i < 16; i++) do_op(1'b0, 8'hC0 | 8'(i), 16'h0, 1'b0);
        ctx = "";
    endtask

    task automatic finish_up;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_up();
    end

    initial begin
        int seed_junk;
        seed_junk = $urandom(32'h5EED);
        for (int i = 0; i < 16; i++) mreg[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        chk("R1 pc after reset", pc_out, 16'h0);
        chk("R1 idle outputs", {12'd0, mem_req, dev_req, op_done, op_busy}, 16'h0);
        dump("R1 reset dump");

        // R2 immediate boundaries
        do_op(1'b0, 8'h80, 16'h0, 1'b0);
        do_op(1'b0, 8'h9F, 16'h0, 1'b0);
        do_op(1'b0, 8'hA0, 16'h0, 1'b0);
        do_op(1'b0, 8'hBF, 16'h0, 1'b0);

        // R4 write then R3 read
        do_op(1'b1, 8'hC3, 16'h1234, 1'b0);
        do_op(1'b0, 8'hC3, 16'h0, 1'b0);
        // R3 post-increment wrap
        do_op(1'b1, 8'hC5, 16'hFFFF, 1'b0);
        do_op(1'b0, 8'hD5, 16'h0, 1'b0);
        do_op(1'b0, 8'hC5, 16'h0, 1'b0);
        chk("R3 wrap to zero", got, 16'h0000);

        // R7 push through register 12 with wrap
        do_op(1'b1, 8'hCC, 16'h0000, 1'b0);
        do_op(1'b1, 8'hFA, 16'hBEEF, 1'b0);
        do_op(1'b0, 8'hCC, 16'h0, 1'b0);
        chk("R7 decrement wrap", got, 16'hFFFF);
        do_op(1'b1, 8'hFA, 16'hCAFE, 1'b0);
        // R6 store through register 10 and post-increment through 11
        do_op(1'b1, 8'hCA, 16'h0400, 1'b0);
        do_op(1'b1, 8'hEA, 16'h5555, 1'b0);
        do_op(1'b1, 8'hCB, 16'h0800, 1'b0);
        do_op(1'b1, 8'hFB, 16'hAAAA, 1'b0);
        do_op(1'b0, 8'hCA, 16'h0, 1'b0);
        chk("R7 register 10 untouched", got, 16'h0400);

        // R10 and R11: fetch through active program counter
        irq_mode = 1'b0;
        do_op(1'b1, 8'hCF, 16'h0100, 1'b0);
        do_op(1'b1, 8'hCE, 16'h0200, 1'b0);
        chk("R10 normal pc", pc_out, 16'h0100);
        do_op(1'b0, 8'hFF, 16'h0, 1'b0);
        chk("R11 immediate word", got, mem_val(16'h0100));
        chk("R11 pc advanced", pc_out, 16'h0101);
        irq_mode = 1'b1;
        @(negedge clk);
        chk("R10 interrupt pc", pc_out, 16'h0200);
        do_op(1'b0, 8'hFE, 16'h0, 1'b0);
        chk("R11 interrupt immediate word", got, mem_val(16'h0200));
        chk("R11 interrupt pc advanced", pc_out, 16'h0201);
        irq_mode = 1'b0;

        // R9 device read and write
        do_op(1'b0, 8'h05, 16'h0, 1'b0);
        do_op(1'b1, 8'h7F, 16'h9876, 1'b0);

        // R12 start while busy is ignored
        do_op(1'b1, 8'hC3, 16'h1111, 1'b0);
        do_op(1'b0, 8'hE3, 16'h0, 1'b1);
        do_op(1'b0, 8'hC3, 16'h0, 1'b0);
        chk("R12 busy start ignored", got, 16'h1111);
        do_op(1'b1, 8'h13, 16'h0, 1'b1);
        do_op(1'b0, 8'hC3, 16'h0, 1'b0);
        chk("R12 busy start ignored on device", got, 16'h1111);

        // R13 destination no-op codes
        do_op(1'b1, 8'h95, 16'h7777, 1'b0);
        do_op(1'b1, 8'hD3, 16'h7777, 1'b0);
        dump("R13 after no-op destinations");

        // random mix
        for (int k = 0; k < 400; k++) begin
            irq_mode = 1'($urandom_range(0, 1));
            do_op(1'($urandom_range(0, 1)), 8'($urandom), 16'($urandom), 1'b0);
        end
        dump("random final dump");
        finish_up();
    end
endmodule